// File: doc/BRIEF.md
# Cascaded Interrupt Controller Pair

This block joins two eight-line interrupt controllers into a cascade. The primary controller takes request lines 0 to 7. The secondary controller takes lines 8 to 15 and feeds its summary into line 2 of the primary. Each controller is programmed through a command offset and a data offset. The command offset selects between an initialization sequence and end-of-interrupt commands. The data offset loads either the vector base or the mask, depending on the controller's state. A separate trigger-select register for each controller picks edge or level sensing for every line.

A single interrupt line goes to the processor. The processor reads `ackVector` to find the service vector of the highest-ranked pending request. Reading `ackVector` has no side effect. Software retires requests by writing end-of-interrupt commands.

Top module: `irq_pair`

## Requirements
- R1: After reset, every pending bit is clear and every mask, vector base and trigger-select register is zero. Both controllers are in normal mode, `cpuIrq` is low and `ackVector` reads 0.
- R2: Writing a byte with bit 4 set to a command offset starts initialization on that controller. Addr 0 is the primary's command offset and addr 2 is the secondary's. The next write to that controller's data offset (addr 1 for the primary, addr 3 for the secondary) loads its vector base with bits 2:0 forced to zero. Later data-offset writes are ignored until the next command-offset write, which returns the controller to normal mode when bit 4 is clear.
- R3: In normal mode, a data-offset write loads the mask. A read of addr 1 or addr 3 returns that controller's mask. A read of addr 0, 2, 6 or 7 returns 0.
- R4: Addr 4 holds the primary's trigger-select register and addr 5 holds the secondary's, each readable and writable. A bit at 1 makes the line level-sensed, so it latches every cycle it is high. A bit at 0 makes the line edge-sensed, so it latches only on a low-to-high change.
- R5: A detected request is latched into the pending register only while its mask bit is 0. Primary input line 2 (`irqIn[2]`) is ignored. Any request latched on the secondary also sets primary pending bit 2.
- R6: A command-offset write with bits 4:3 = 00 and bits 7:5 = 001 clears all pending bits of that controller. On the secondary it also clears primary bit 2.
- R7: A command-offset write with bits 4:3 = 00 and bits 7:5 = 011 clears only the pending bit numbered by bits 2:0. On the secondary it clears primary bit 2 only if no secondary bit remains. Any other command with bit 4 clear has no effect on pending bits.
- R8: `cpuIrq` is high exactly when the primary has at least one pending bit.
- R9: `ackVector` gives the first pending request in this order: primary 0, primary 1, then secondary 0 to 7 (only while primary bit 2 is pending), then primary 3 to 7. Its value is that controller's base plus the line number. It is 0 when nothing qualifies.
- R10: When an end-of-interrupt and a new request for the same bit fall in the same cycle, the clear is applied first, so the new request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for one cycle |
| addr | input | 3 | Register select (see R2 to R4) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |
| irqIn | input | 16 | Request lines; bits 7:0 primary, 15:8 secondary |
| cpuIrq | output | 1 | Interrupt to the processor |
| ackVector | output | 8 | Vector of the highest-ranked pending request |

## Verification
The hardest state to reach is one where both controllers hold several pending bits and a secondary end-of-interrupt either empties the secondary or leaves bits behind. Only that difference decides whether primary bit 2 survives and whether the acknowledge order jumps back to primary lines 3 to 7. Directed sequences build these cases explicitly, including a specific clear of the last secondary bit and a clear that coincides with a fresh request. A long seeded random run then mixes sparse request patterns with weighted end-of-interrupt, mask, trigger-select and initialization writes, and checks them against a bench model.

// File: rtl/irq_pair_pkg.sv
package irq_pair_pkg;
  localparam int NUM_CTRL = 2;
  localparam int LINES    = 8;
  localparam int LVL_W    = $clog2(LINES);
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 8;
  localparam int CASC_BIT = 2;

  localparam logic [2:0] OP_EOI_ALL = 3'b001;
  localparam logic [2:0] OP_EOI_ONE = 3'b011;

  typedef enum logic [1:0] {
    MODE_RUN       = 2'd0,
    MODE_WAIT_BASE = 2'd1,
    MODE_SKIP      = 2'd2
  } ctrl_mode_t;

  typedef struct packed {
    logic [NUM_CTRL-1:0] baseLoad;
    logic [NUM_CTRL-1:0] maskLoad;
    logic [NUM_CTRL-1:0] trigLoad;
    logic [NUM_CTRL-1:0] eoiAll;
    logic [NUM_CTRL-1:0] eoiOne;
    logic [LVL_W-1:0]    level;
    logic [DATA_W-1:0]   data;
  } ctrl_strobe_t;
endpackage

// File: rtl/irq_pair_ctrl.sv
module irq_pair_ctrl
  import irq_pair_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output ctrl_strobe_t      stb
);
  logic [NUM_CTRL-1:0] baseLoadV, maskLoadV, trigLoadV, eoiAllV, eoiOneV;

  for (genvar c = 0; c < NUM_CTRL; c++) begin : g_ctl
    ctrl_mode_t mode;
    logic isCmd, isDat, isTrig;

    assign isCmd  = wrEn && (addr == ADDR_W'(2 * c));
    assign isDat  = wrEn && (addr == ADDR_W'(2 * c + 1));
    assign isTrig = wrEn && (addr == ADDR_W'(2 * NUM_CTRL + c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mode <= MODE_RUN;
      end else if (isCmd) begin
        mode <= wrData[4] ? MODE_WAIT_BASE : MODE_RUN;
      end else if (isDat && mode == MODE_WAIT_BASE) begin
        mode <= MODE_SKIP;
      end
    end

    assign baseLoadV[c] = isDat && (mode == MODE_WAIT_BASE);
    assign maskLoadV[c] = isDat && (mode == MODE_RUN);
    assign trigLoadV[c] = isTrig;
    assign eoiAllV[c]   = isCmd && (wrData[4:3] == 2'b00) && (wrData[7:5] == OP_EOI_ALL);
    assign eoiOneV[c]   = isCmd && (wrData[4:3] == 2'b00) && (wrData[7:5] == OP_EOI_ONE);
  end

  always_comb begin
    stb.baseLoad = baseLoadV;
    stb.maskLoad = maskLoadV;
    stb.trigLoad = trigLoadV;
    stb.eoiAll   = eoiAllV;
    stb.eoiOne   = eoiOneV;
    stb.level    = wrData[LVL_W-1:0];
    stb.data     = wrData;
  end
endmodule

// File: rtl/irq_pair_dp.sv
module irq_pair_dp
  import irq_pair_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrl_strobe_t              stb,
  input  logic [NUM_CTRL*LINES-1:0] irqIn,
  input  logic [ADDR_W-1:0]         addr,
  output logic [DATA_W-1:0]         rdData,
  output logic [DATA_W-1:0]         ackVector,
  output logic                      cpuIrq,
  output logic [LINES-1:0]          masterAsr,
  output logic [LINES-1:0]          slaveAsr,
  output logic [LINES-1:0]          slaveMask
);
  localparam logic [LINES-1:0]  CASC_ONEHOT = LINES'(1) << CASC_BIT;
  localparam logic [DATA_W-1:0] BASE_KEEP   = ~DATA_W'(LINES - 1);

  logic [LINES-1:0]  asr     [NUM_CTRL];
  logic [LINES-1:0]  nextAsr [NUM_CTRL];
  logic [LINES-1:0]  mask    [NUM_CTRL];
  logic [LINES-1:0]  trig    [NUM_CTRL];
  logic [LINES-1:0]  prevIn  [NUM_CTRL];
  logic [LINES-1:0]  newReq  [NUM_CTRL];
  logic [LINES-1:0]  clrOwn  [NUM_CTRL];
  logic [DATA_W-1:0] base    [NUM_CTRL];

  for (genvar c = 0; c < NUM_CTRL; c++) begin : g_ch
    logic [LINES-1:0] lines, raw, inKeep;
    assign lines  = irqIn[c*LINES +: LINES];
    assign raw    = (trig[c] & lines) | (~trig[c] & lines & ~prevIn[c]);
    assign inKeep = (c == 0) ? ~CASC_ONEHOT : '1;
    assign newReq[c] = raw & ~mask[c] & inKeep;
    assign clrOwn[c] = stb.eoiAll[c] ? '1 :
                       stb.eoiOne[c] ? (LINES'(1) << stb.level) : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        asr[c]    <= '0;
        mask[c]   <= '0;
        trig[c]   <= '0;
        prevIn[c] <= '0;
        base[c]   <= '0;
      end else begin
        asr[c]    <= nextAsr[c];
        prevIn[c] <= lines;
        if (stb.maskLoad[c]) mask[c] <= stb.data[LINES-1:0];
        if (stb.trigLoad[c]) trig[c] <= stb.data[LINES-1:0];
        if (stb.baseLoad[c]) base[c] <= stb.data & BASE_KEEP;
      end
    end
  end

  logic [LINES-1:0] slaveLeft;
  logic             cascClr;

  always_comb begin
    slaveLeft  = asr[1] & ~clrOwn[1];
    cascClr    = stb.eoiAll[1] || (stb.eoiOne[1] && slaveLeft == '0);
    nextAsr[1] = slaveLeft | newReq[1];
    nextAsr[0] = asr[0] & ~clrOwn[0];
    if (cascClr) nextAsr[0][CASC_BIT] = 1'b0;
    nextAsr[0] = nextAsr[0] | newReq[0];
    if (newReq[1] != '0) nextAsr[0][CASC_BIT] = 1'b1;
  end

  logic hit;
  always_comb begin
    ackVector = '0;
    hit       = 1'b0;
    for (int i = 0; i < CASC_BIT; i++) begin
      if (!hit && asr[0][i]) begin
        ackVector = base[0] | DATA_W'(i);
        hit       = 1'b1;
      end
    end
    if (!hit && asr[0][CASC_BIT]) begin
      for (int i = 0; i < LINES; i++) begin
        if (!hit && asr[1][i]) begin
          ackVector = base[1] | DATA_W'(i);
          hit       = 1'b1;
        end
      end
    end
    for (int i = CASC_BIT + 1; i < LINES; i++) begin
      if (!hit && asr[0][i]) begin
        ackVector = base[0] | DATA_W'(i);
        hit       = 1'b1;
      end
    end
  end

  always_comb begin
    case (addr)
      3'd1:    rdData = mask[0];
      3'd3:    rdData = mask[1];
      3'd4:    rdData = trig[0];
      3'd5:    rdData = trig[1];
      default: rdData = '0;
    endcase
  end

  assign cpuIrq    = |asr[0];
  assign masterAsr = asr[0];
  assign slaveAsr  = asr[1];
  assign slaveMask = mask[1];
endmodule

// File: rtl/irq_pair.sv
module irq_pair
  import irq_pair_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wrData,
  output logic [DATA_W-1:0]         rdData,
  input  logic [NUM_CTRL*LINES-1:0] irqIn,
  output logic                      cpuIrq,
  output logic [DATA_W-1:0]         ackVector
);
  ctrl_strobe_t     stb;
  logic [LINES-1:0] masterAsrW, slaveAsrW, slaveMaskW;

  irq_pair_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .stb(stb)
  );

  irq_pair_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .irqIn(irqIn), .addr(addr),
    .rdData(rdData), .ackVector(ackVector), .cpuIrq(cpuIrq),
    .masterAsr(masterAsrW), .slaveAsr(slaveAsrW), .slaveMask(slaveMaskW)
  );
endmodule

// File: rtl/irq_pair_chk.sv
module irq_pair_chk
  import irq_pair_pkg::*;
(
  input logic                      clk,
  input logic                      rstN,
  input logic                      wrEn,
  input logic [ADDR_W-1:0]         addr,
  input logic [DATA_W-1:0]         wrData,
  input logic [NUM_CTRL*LINES-1:0] irqIn,
  input logic                      cpuIrq,
  input logic [DATA_W-1:0]         ackVector,
  input logic [LINES-1:0]          masterAsr,
  input logic [LINES-1:0]          slaveAsr,
  input logic [LINES-1:0]          slaveMask
);
  // R9: with no primary request pending the acknowledge value is zero
  assert_ack_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !cpuIrq |-> ackVector == '0);

  // R6: clear-all on the secondary with quiet inputs empties it and drops the cascade bit
  assert_slave_clear_all_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd2 && wrData[7:3] == 5'b00100 && irqIn[15:8] == '0)
    |=> (slaveAsr == '0 && !masterAsr[CASC_BIT]));

  // R8: clear-all on the primary with quiet inputs drops the processor interrupt
  assert_irq_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd0 && wrData[7:3] == 5'b00100 && irqIn == '0)
    |=> !cpuIrq);

  // R5: masked secondary lines never become pending while the mask is unchanged
  assert_mask_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((slaveAsr & slaveMask) == '0 && !wrEn) |=> (slaveAsr & slaveMask) == '0);

  // R5: a secondary request arriving appears at the primary cascade input
  assert_cascade_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|slaveAsr) |-> masterAsr[CASC_BIT]);
endmodule

bind irq_pair irq_pair_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .irqIn(irqIn), .cpuIrq(cpuIrq), .ackVector(ackVector),
  .masterAsr(masterAsrW), .slaveAsr(slaveAsrW), .slaveMask(slaveMaskW)
);

// File: tb/irq_pair_bench.sv
`timescale 1ns/1ps
module irq_pair_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [2:0]  addr;
  logic [7:0]  wrData;
  logic [7:0]  rdData;
  logic [15:0] irqIn;
  logic        cpuIrq;
  logic [7:0]  ackVector;

  int testCnt = 0;
  int failCnt = 0;

  always #10 clk = ~clk;

  irq_pair u_irq_pair (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irqIn(irqIn), .cpuIrq(cpuIrq), .ackVector(ackVector)
  );

  // bench model of the requirements
  logic [7:0] mA[2], mMask[2], mBase[2], mTrig[2], mPrev[2];
  int         mMode[2];  // 0 normal, 1 waiting for base, 2 ignoring data

  task automatic modelReset();
    for (int c = 0; c < 2; c++) begin
      mA[c] = 0; mMask[c] = 0; mBase[c] = 0; mTrig[c] = 0; mPrev[c] = 0; mMode[c] = 0;
    end
  endtask

  task automatic modelClock(bit we, logic [2:0] a, logic [7:0] d, logic [15:0] irq);
    logic [7:0] clr[2];
    logic [7:0] nw[2];
    logic [7:0] lines, raw, left;
    bit cmd, dat, cc;
    cc = 0;
    for (int c = 0; c < 2; c++) begin
      lines = irq[c*8 +: 8];
      raw   = (mTrig[c] & lines) | (~mTrig[c] & lines & ~mPrev[c]);
      nw[c] = raw & ~mMask[c];
      if (c == 0) nw[0][2] = 1'b0;
      clr[c] = 0;
      cmd = we && (a == 3'(2 * c));
      if (cmd && d[4:3] == 0 && d[7:5] == 3'b001) clr[c] = 8'hff;
      if (cmd && d[4:3] == 0 && d[7:5] == 3'b011) clr[c] = 8'h01 << d[2:0];
      if (c == 1 && cmd && d[4:3] == 0 && d[7:5] == 3'b001) cc = 1;
    end
    left = mA[1] & ~clr[1];
    if (we && a == 3'd2 && d[4:3] == 0 && d[7:5] == 3'b011 && left == 0) cc = 1;
    mA[1] = left | nw[1];
    mA[0] = mA[0] & ~clr[0];
    if (cc) mA[0][2] = 1'b0;
    mA[0] = mA[0] | nw[0];
    if (nw[1] != 0) mA[0][2] = 1'b1;
    for (int c = 0; c < 2; c++) begin
      cmd = we && (a == 3'(2 * c));
      dat = we && (a == 3'(2 * c + 1));
      if (dat && mMode[c] == 1) begin
        mBase[c] = d & 8'hf8; mMode[c] = 2;
      end else if (dat && mMode[c] == 0) begin
        mMask[c] = d;
      end
      if (cmd) mMode[c] = d[4] ? 1 : 0;
      if (we && a == 3'(4 + c)) mTrig[c] = d;
      mPrev[c] = irq[c*8 +: 8];
    end
  endtask

  function automatic logic [7:0] expAck();
    for (int i = 0; i < 2; i++) if (mA[0][i]) return mBase[0] + 8'(i);
    if (mA[0][2]) for (int i = 0; i < 8; i++) if (mA[1][i]) return mBase[1] + 8'(i);
    for (int i = 3; i < 8; i++) if (mA[0][i]) return mBase[0] + 8'(i);
    return 8'h00;
  endfunction

  function automatic logic [7:0] expRd(logic [2:0] a);
    case (a)
      3'd1: return mMask[0];
      3'd3: return mMask[1];
      3'd4: return mTrig[0];
      3'd5: return mTrig[1];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R9 ack vector", ackVector, expAck());
    chk("R8 cpu irq", {7'd0, cpuIrq}, {7'd0, mA[0] != 0});
    chk("R3/R4 read data", rdData, expRd(addr));
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(bit we, logic [2:0] a, logic [7:0] d, logic [15:0] irq);
    wrEn = we; addr = a; wrData = d; irqIn = irq;
    @(posedge clk);
    modelClock(we, a, d, irq);
    @(negedge clk);
    wrEn = 0;
    compareAll();
  endtask

  task automatic randomStep();
    int r;
    logic [2:0] a;
    logic [7:0] d;
    bit we;
    r  = int'($urandom % 16);
    we = (r >= 6);
    a  = 3'($urandom % 8);
    case ($urandom % 8)
      0, 1: d = 8'h20;
      2, 3: d = {5'b01100, 3'($urandom % 8)};
      4:    d = 8'h08;
      5:    d = (($urandom % 6) == 0) ? 8'h11 : 8'h40;
      default: d = 8'($urandom & $urandom);
    endcase
    if (a[0] || a[2]) d = 8'($urandom & $urandom & $urandom);
    step(we, a, d, 16'($urandom & $urandom & $urandom));
  endtask

  initial begin
    void'($urandom(32'h5eed_0c1a));
    rstN = 0; wrEn = 0; addr = 0; wrData = 0; irqIn = 0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1 ack after reset", ackVector, 8'h00);
    chk("R1 irq after reset", {7'd0, cpuIrq}, 8'h00);
    addr = 3'd1; #1; chk("R1 primary mask after reset", rdData, 8'h00);
    addr = 3'd5; #1; chk("R1 trigger select after reset", rdData, 8'h00);
    @(negedge clk);

    // R2 initialization of both controllers
    step(1, 3'd0, 8'h11, 0);
    step(1, 3'd1, 8'h27, 0);
    step(1, 3'd1, 8'h55, 0);
    step(0, 3'd1, 8'h00, 0);
    chk("R2 data write ignored after base", rdData, 8'h00);
    step(1, 3'd0, 8'h08, 0);
    step(1, 3'd2, 8'h13, 0);
    step(1, 3'd3, 8'h2f, 0);
    step(1, 3'd2, 8'h08, 0);
    step(1, 3'd3, 8'h00, 0);

    // R9 priority through the cascade
    step(0, 3'd0, 0, 16'h0008);
    chk("R2 base low bits forced", ackVector, 8'h23);
    step(0, 3'd0, 0, 16'h2008);
    chk("R9 secondary ranks ahead of primary 3", ackVector, 8'h2d);
    chk("R5 cascade raises cpu irq", {7'd0, cpuIrq}, 8'h01);
    step(1, 3'd2, 8'h65, 0);
    chk("R7 last secondary cleared drops cascade", ackVector, 8'h23);
    step(1, 3'd0, 8'h20, 0);
    chk("R6 clear-all primary", {7'd0, cpuIrq}, 8'h00);
    chk("R9 nothing pending gives zero", ackVector, 8'h00);

    // R7 specific clear leaves cascade while secondary bits remain
    step(0, 3'd0, 0, 16'h0600);
    step(1, 3'd2, 8'h61, 0);
    chk("R7 cascade kept while secondary pending", ackVector, 8'h2a);
    step(1, 3'd2, 8'h40, 0);
    chk("R7 other command has no effect", ackVector, 8'h2a);
    step(1, 3'd2, 8'h20, 0);
    chk("R6 clear-all secondary", {7'd0, cpuIrq}, 8'h00);

    // R5 mask and ignored line 2
    step(1, 3'd1, 8'h01, 0);
    step(0, 3'd0, 0, 16'h0001);
    chk("R5 masked line not latched", {7'd0, cpuIrq}, 8'h00);
    step(0, 3'd0, 0, 16'h0004);
    chk("R5 primary input 2 ignored", {7'd0, cpuIrq}, 8'h00);
    step(1, 3'd1, 8'h00, 0);
    chk("R5 masked request still absent after unmask", {7'd0, cpuIrq}, 8'h00);

    // R4 and R10 level sensing with coincident clear
    step(1, 3'd4, 8'h02, 0);
    chk("R4 trigger select readback", rdData, 8'h02);
    step(0, 3'd0, 0, 16'h0002);
    step(1, 3'd0, 8'h20, 16'h0002);
    chk("R10 level request survives coincident clear", ackVector, 8'h21);
    step(1, 3'd0, 8'h20, 16'h0000);
    chk("R4 level line gone after release", {7'd0, cpuIrq}, 8'h00);
    step(1, 3'd4, 8'h00, 0);
    step(0, 3'd0, 0, 16'h0010);
    step(1, 3'd0, 8'h20, 16'h0010);
    chk("R4 edge line held high does not relatch", {7'd0, cpuIrq}, 8'h00);
    step(0, 3'd0, 0, 0);

    for (int n = 0; n < 4000; n++) randomStep();

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule